// File: doc/BRIEF.md
# Ring Rogue Packet Remover

This block sits in the forwarding path of one node on a unidirectional packet ring and keeps packets from circling forever. Every packet carries a header with the originating node's ID and two mark bits. When a packet arrives whose source ID equals the local node ID, the node is its originator. The block takes it off the ring and pulses an own-data indication.

A node can also take up one or both of two independent rogue-master roles. Role 0 owns mark bit 0 and role 1 owns mark bit 1. An enabled role sets its bit on every packet it forwards. If a packet comes back with that bit already set, it has gone all the way round without being stripped by its originator. The block then drops it and raises a sticky fault flag, which can drive an interrupt. Each role is meant to be active on exactly one node of the ring. The two roles use separate bits, so each one checks the other.

Packets enter and leave through valid/ready handshakes. A packet transfers on a cycle where valid and ready are both high. Once out_valid is asserted, it stays high and the output fields stay stable until out_ready is seen high. in_ready falls only when the output register holds a packet that the downstream side is not taking. A packet that will be removed is still accepted in that case, since it needs no output slot.

Top module: `ring_rogue_filter`

## Requirements
- R1: After reset, out_valid, own_seen, fault_flag and irq are 0, and in_ready is 1.
- R2: A packet whose source ID differs from node_id, and that carries no mark bit owned by an enabled role, is forwarded. Its source ID and payload are unchanged, it appears on out_valid the cycle after acceptance, and packets leave in the order they arrived.
- R3: Mark bit 0 belongs to role 0 (rm0_en) and mark bit 1 to role 1 (rm1_en). A forwarded packet leaves with the bit of every enabled role set. The bit of a disabled role passes through unchanged.
- R4: A packet whose source ID equals node_id is not forwarded, whatever its mark bits. own_seen is 1 for exactly the one cycle after its acceptance.
- R5: A packet with a foreign source ID that carries the mark bit of an enabled role is not forwarded. fault_flag reads 1 from the cycle after its acceptance.
- R6: fault_flag stays 1 until a cycle with fault_clr high and no new rogue acceptance. If a rogue packet is accepted in the same cycle as fault_clr, the flag stays set.
- R7: irq equals fault_flag AND irq_en.
- R8: While out_valid is 1 and out_ready is 0, the output fields hold steady. In that state in_ready is 0 for a packet that would be forwarded.
- R9: A packet that will be removed (by R4 or R5) is accepted even while the output is stalled, and it does not disturb the held output.
- R10: Role bits are independent. A bit owned only by a disabled role never causes removal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | ID_W | Local node ID |
| rm0_en | input | 1 | Enables rogue-master role 0 (mark bit 0) |
| rm1_en | input | 1 | Enables rogue-master role 1 (mark bit 1) |
| in_valid | input | 1 | Incoming packet valid |
| in_ready | output | 1 | Block accepts the incoming packet |
| in_src | input | ID_W | Incoming source ID |
| in_mark | input | 2 | Incoming mark bits |
| in_payload | input | DATA_W | Incoming payload |
| out_valid | output | 1 | Outgoing packet valid |
| out_ready | input | 1 | Downstream accepts the outgoing packet |
| out_src | output | ID_W | Outgoing source ID |
| out_mark | output | 2 | Outgoing mark bits |
| out_payload | output | DATA_W | Outgoing payload |
| own_seen | output | 1 | One-cycle pulse when an own packet is stripped |
| fault_clr | input | 1 | Write-one-to-clear strobe for the fault flag |
| irq_en | input | 1 | Interrupt enable for the fault flag |
| fault_flag | output | 1 | Sticky rogue-packet fault |
| irq | output | 1 | Fault interrupt |

## Verification
The assertions assume that node_id, rm0_en and rm1_en change only while no packet is waiting in the output register. The check that no forwarded packet carries the local ID depends on this, because it compares a held packet against the current node_id. The bench changes the configuration only after its scoreboard has drained and the input is idle. It drives in_valid and the packet fields only from its send task, so the input never changes on its own in mid-handshake except in the one directed case that turns a stalled forward into a strip. Random back-pressure is switched off in the directed stall and flag checks, so the expected cycles can be counted exactly.

// File: rtl/ring_rogue_pkg.sv
package ring_rogue_pkg;
  localparam int NUM_ROLES = 2;

  typedef enum logic [1:0] {
    VERDICT_FWD   = 2'd0,
    VERDICT_STRIP = 2'd1,
    VERDICT_ROGUE = 2'd2
  } verdict_e;
endpackage

// File: rtl/rr_classify.sv
module rr_classify
  import ring_rogue_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int ROLES = NUM_ROLES
) (
  input  logic [ID_W-1:0]  src,
  input  logic [ID_W-1:0]  node_id,
  input  logic [ROLES-1:0] mark_in,
  input  logic [ROLES-1:0] role_en,
  output verdict_e         verdict,
  output logic [ROLES-1:0] mark_out
);
  logic [ROLES-1:0] hit;

  for (genvar k = 0; k < ROLES; k++) begin : g_role
    assign hit[k]      = role_en[k] & mark_in[k];
    assign mark_out[k] = mark_in[k] | role_en[k];
  end

  // originator stripping outranks the rogue check
  always_comb begin
    if (src == node_id)  verdict = VERDICT_STRIP;
    else if (|hit)       verdict = VERDICT_ROGUE;
    else                 verdict = VERDICT_FWD;
  end
endmodule

// File: rtl/rr_out_stage.sv
module rr_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));
endmodule

// File: rtl/rr_fault_flag.sv
module rr_fault_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_i)  flag <= 1'b1;
    else if (clr_i)  flag <= 1'b0;
  end

  assign irq = flag & irq_en;

  // R5
  fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag);
  // R6
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_i) |=> flag);
  // R6
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag);
endmodule

// File: rtl/ring_rogue_filter.sv
module ring_rogue_filter
  import ring_rogue_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   node_id,
  input  logic              rm0_en,
  input  logic              rm1_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ID_W-1:0]   in_src,
  input  logic [1:0]        in_mark,
  input  logic [DATA_W-1:0] in_payload,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_src,
  output logic [1:0]        out_mark,
  output logic [DATA_W-1:0] out_payload,
  output logic              own_seen,
  input  logic              fault_clr,
  input  logic              irq_en,
  output logic              fault_flag,
  output logic              irq
);
  localparam int PKT_W = ID_W + NUM_ROLES + DATA_W;

  verdict_e             verdict;
  logic [NUM_ROLES-1:0] mark_fwd;
  logic                 stage_ready;
  logic                 drop;
  logic                 take;
  logic [PKT_W-1:0]     pkt_in;
  logic [PKT_W-1:0]     pkt_out;

  rr_classify #(.ID_W(ID_W), .ROLES(NUM_ROLES)) u_classify (
    .src      (in_src),
    .node_id  (node_id),
    .mark_in  (in_mark),
    .role_en  ({rm1_en, rm0_en}),
    .verdict  (verdict),
    .mark_out (mark_fwd)
  );

  assign drop     = (verdict != VERDICT_FWD);
  assign in_ready = drop || stage_ready;
  assign take     = in_valid && in_ready;
  assign pkt_in   = {in_src, mark_fwd, in_payload};

  rr_out_stage #(.W(PKT_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid && !drop),
    .up_ready (stage_ready),
    .up_data  (pkt_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pkt_out)
  );

  assign {out_src, out_mark, out_payload} = pkt_out;

  always_ff @(posedge clk) begin
    if (!rst_n) own_seen <= 1'b0;
    else        own_seen <= take && (verdict == VERDICT_STRIP);
  end

  rr_fault_flag u_fault (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (take && (verdict == VERDICT_ROGUE)),
    .clr_i  (fault_clr),
    .irq_en (irq_en),
    .flag   (fault_flag),
    .irq    (irq)
  );

  // R4
  own_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_src == node_id) |=> own_seen);
  // R4
  no_own_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_src != node_id));
  // R9
  drop_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_src == node_id) |-> in_ready);
endmodule

// File: tb/ring_rogue_filter_tb_top.sv
module ring_rogue_filter_tb_top;
  localparam int ID_W = 8;
  localparam int DW   = 32;
  localparam int PW   = ID_W + 2 + DW;

  logic clk = 0, rst_n = 0;
  logic [ID_W-1:0] node_id = 8'd5;
  logic rm0_en = 0, rm1_en = 0;
  logic in_valid = 0, in_ready;
  logic [ID_W-1:0] in_src = '0;
  logic [1:0] in_mark = '0;
  logic [DW-1:0] in_payload = '0;
  logic out_valid, out_ready = 1;
  logic [ID_W-1:0] out_src;
  logic [1:0] out_mark;
  logic [DW-1:0] out_payload;
  logic own_seen, fault_clr = 0, irq_en = 0, fault_flag, irq;

  int checks = 0, fails = 0;
  int exp_own = 0, obs_own = 0;
  bit rand_bp = 0, clr_with_send = 0, done = 0;
  logic [PW-1:0] sb_q[$];

  always #4 clk = ~clk;

  ring_rogue_filter #(.ID_W(ID_W), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .node_id(node_id), .rm0_en(rm0_en), .rm1_en(rm1_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src), .in_mark(in_mark),
    .in_payload(in_payload), .out_valid(out_valid), .out_ready(out_ready),
    .out_src(out_src), .out_mark(out_mark), .out_payload(out_payload),
    .own_seen(own_seen), .fault_clr(fault_clr), .irq_en(irq_en),
    .fault_flag(fault_flag), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // 0 forward, 1 strip, 2 rogue
  function automatic int kind_of(input logic [ID_W-1:0] s, input logic [1:0] m);
    if (s == node_id) return 1;
    if ((m & {rm1_en, rm0_en}) != 2'b00) return 2;
    return 0;
  endfunction

  task automatic send(input logic [ID_W-1:0] s, input logic [1:0] m, input logic [DW-1:0] p);
    int k;
    k = kind_of(s, m);
    @(negedge clk);
    in_valid = 1; in_src = s; in_mark = m; in_payload = p;
    fault_clr = clr_with_send;
    #3;
    while (!in_ready) begin @(negedge clk); #3; end
    if (k == 0) sb_q.push_back({s, m | {rm1_en, rm0_en}, p});
    if (k == 1) exp_own++;
    @(posedge clk);
    #1 in_valid = 0; fault_clr = 0;
  endtask

  task automatic drain();
    int n = 0;
    while (sb_q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  // scoreboard monitor: R2, R3
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb_q.size() == 0) chk(0, "R2 unexpected output", {out_src, out_mark, out_payload}, 0);
      else begin
        logic [PW-1:0] e;
        e = sb_q.pop_front();
        chk({out_src, out_mark, out_payload} == e, "R2/R3 forwarded packet",
            {out_src, out_mark, out_payload}, e);
      end
    end
    if (rst_n && own_seen) obs_own++;
  end

  always @(posedge clk) begin
    #2;
    if (rand_bp) out_ready = ($urandom % 4) != 0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(own_seen == 0, "R1 own_seen", own_seen, 0);
    chk(fault_flag == 0, "R1 fault_flag", fault_flag, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    rst_n = 1;

    // role 0 only
    rm0_en = 1;
    send(8'd3, 2'b00, 32'h1111_0001);   // R2, R3: leaves with mark 01
    send(8'd9, 2'b10, 32'h1111_0002);   // R10: bit 1 not owned, leaves 11
    drain();
    chk(fault_flag == 0, "R10 no fault from unowned bit", fault_flag, 0);

    // R4 strip, marks ignored
    send(8'd5, 2'b01, 32'h2222_0001);
    @(negedge clk);
    chk(own_seen == 1, "R4 own_seen pulse", own_seen, 1);
    @(negedge clk);
    chk(own_seen == 0, "R4 own_seen one cycle", own_seen, 0);
    chk(fault_flag == 0, "R4 strip outranks rogue", fault_flag, 0);
    chk(out_valid == 0, "R4 nothing forwarded", out_valid, 0);

    // R5 rogue removal
    send(8'd3, 2'b01, 32'h3333_0001);
    @(negedge clk);
    chk(fault_flag == 1, "R5 fault set", fault_flag, 1);
    chk(out_valid == 0, "R5 rogue not forwarded", out_valid, 0);
    chk(irq == 0, "R7 irq masked", irq, 0);
    irq_en = 1; #1;
    chk(irq == 1, "R7 irq enabled", irq, 1);
    repeat (4) @(negedge clk);
    chk(fault_flag == 1, "R6 flag sticky", fault_flag, 1);
    fault_clr = 1; @(negedge clk); fault_clr = 0;
    chk(fault_flag == 0, "R6 flag cleared", fault_flag, 0);
    chk(irq == 0, "R7 irq follows flag", irq, 0);
    clr_with_send = 1;
    send(8'd4, 2'b11, 32'h3333_0002);
    clr_with_send = 0;
    @(negedge clk);
    chk(fault_flag == 1, "R6 set wins over clear", fault_flag, 1);
    fault_clr = 1; @(negedge clk); fault_clr = 0; irq_en = 0;

    // role 1 only
    rm0_en = 0; rm1_en = 1;
    send(8'd7, 2'b01, 32'h4444_0001);   // R10: leaves 11
    drain();
    chk(fault_flag == 0, "R10 bit 0 ignored by role 1", fault_flag, 0);
    send(8'd7, 2'b10, 32'h4444_0002);   // rogue for role 1
    @(negedge clk);
    chk(fault_flag == 1, "R5 role 1 rogue", fault_flag, 1);
    fault_clr = 1; @(negedge clk); fault_clr = 0;

    // both roles
    rm0_en = 1;
    send(8'd8, 2'b00, 32'h5555_0001);   // R3: leaves 11
    send(8'd8, 2'b01, 32'h5555_0002);   // rogue
    drain();
    chk(fault_flag == 1, "R5 both roles rogue", fault_flag, 1);
    fault_clr = 1; @(negedge clk); fault_clr = 0;

    // R8 / R9 back-pressure
    @(posedge clk); #2 out_ready = 0;
    send(8'd2, 2'b00, 32'h6666_0001);
    @(negedge clk);
    chk(out_valid == 1, "R8 held valid", out_valid, 1);
    held = out_payload;
    in_valid = 1; in_src = 8'd2; in_mark = 2'b00; in_payload = 32'h6666_0002;
    #3;
    chk(in_ready == 0, "R8 forward blocked while stalled", in_ready, 0);
    @(negedge clk);
    chk(out_payload == held && out_valid, "R8 output stable", out_payload, held);
    in_src = 8'd5; in_payload = 32'h6666_0003;
    #3;
    chk(in_ready == 1, "R9 strip accepted while stalled", in_ready, 1);
    exp_own++;
    @(posedge clk); #1 in_valid = 0;
    @(negedge clk);
    chk(own_seen == 1, "R9 own_seen while stalled", own_seen, 1);
    chk(out_payload == held && out_valid, "R9 held output undisturbed", out_payload, held);
    out_ready = 1;
    send(8'd2, 2'b00, 32'h6666_0004);
    drain();

    // random traffic with back-pressure
    begin
      bit any_rogue = 0;
      rand_bp = 1;
      for (int cfg = 0; cfg < 4; cfg++) begin
        rm0_en = cfg[0]; rm1_en = cfg[1]; node_id = 8'(cfg + 1);
        for (int i = 0; i < 150; i++) begin
          logic [ID_W-1:0] s;
          logic [1:0] m;
          s = 8'($urandom % 6);
          m = 2'($urandom);
          if (kind_of(s, m) == 2) any_rogue = 1;
          send(s, m, $urandom);
        end
        drain();
      end
      rand_bp = 0; out_ready = 1;
      repeat (4) @(negedge clk);
      chk(fault_flag == any_rogue, "R5 random rogue flag", fault_flag, any_rogue);
    end

    chk(obs_own == exp_own, "R4 own pulse count", obs_own, exp_own);
    chk(sb_q.size() == 0, "R2 scoreboard drained", sb_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule